// File: doc/BRIEF.md
# Label-filtering data match engine

This block decides where a received data word belongs. Words arrive from one of four serial receive channels, each tagged with its channel number. The host loads a table of 128 sixteen-bit match entries, and the engine walks that table from the lowest index upward until it finds the first entry whose label, source/destination and channel conditions all accept the word. The index of that entry is the word's slot in receive storage. The entry also says whether the word should be copied into the receiving channel's FIFO, and which of three interrupt lines, if any, to raise.

The engine takes one word at a time. It raises a busy output from the moment it accepts a word until it reports the result. A result is a one-cycle valid pulse with a hit flag, the slot address, the FIFO flag and the interrupt select. A word that no entry accepts is reported as a miss and is not stored anywhere. Host table writes take priority over the scan. Each write holds the scan on its current entry for one cycle.

Entry layout (bit 15 down to 0): interrupt select [15:14], channel [13:12], FIFO copy [11], source/destination don't-care [10], source/destination [9:8], label [7:0]. The received word supplies its label in bits [7:0] and its source/destination pair in bits [9:8].

Top module: `lbl_match_engine`

## Requirements
- R1: A host write with address 0x200 to 0x27F stores the data into entry (address − 0x200). Writes to any other address leave the table unchanged.
- R2: The label condition holds when entry bits [7:0] are zero, or when they equal word bits [7:0].
- R3: The source/destination condition holds when entry bit 10 is 1, or when entry bits [9:8] equal word bits [9:8].
- R4: The source/destination condition also holds when the word's pair is 00 and the all-call enable bit for the receiving channel was 1 when the word was accepted. Enable bits of other channels have no effect.
- R5: The channel condition holds only when entry bits [13:12] equal the word's channel number.
- R6: Among the entries that satisfy all three conditions, the lowest index wins. res_addr_o reports that index.
- R7: On a hit, res_fifo_o equals entry bit 11 and res_irq_o equals entry bits [15:14]. The value 0 means no interrupt, and 1 to 3 select an interrupt line.
- R8: If no entry matches, the result has res_hit_o = 0, and res_addr_o, res_fifo_o and res_irq_o are all 0.
- R9: With no host writes, a hit on entry k is reported k+1 cycles after the accepting edge, and a miss 128 cycles after it. res_vld_o is high for exactly one cycle.
- R10: busy_o rises on the edge that accepts a word and falls with the result. A word presented while busy_o is high is ignored and produces no result.
- R11: Each cycle with tbl_we_i high during a scan holds the scan on its current entry, delaying the result by one cycle.
- R12: After reset, busy_o and res_vld_o are 0, and every table entry is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| word_vld_i | input | 1 | Received-word strobe; taken only while busy_o is low |
| word_i | input | 10 | Received word bits 9:0 (source/destination [9:8], label [7:0]) |
| word_ch_i | input | 2 | Receiving channel number |
| all_call_i | input | 4 | Per-channel all-call enable |
| tbl_we_i | input | 1 | Host table write strobe |
| tbl_addr_i | input | 10 | Host write address |
| tbl_wdata_i | input | 16 | Host write data (match entry) |
| busy_o | output | 1 | Scan in progress |
| res_vld_o | output | 1 | One-cycle result strobe |
| res_hit_o | output | 1 | A matching entry was found |
| res_addr_o | output | 7 | Storage slot (matching entry index) |
| res_fifo_o | output | 1 | Also copy the word to the channel FIFO |
| res_irq_o | output | 2 | Interrupt select, 0 = none |

## Verification
Every result is due a fixed number of cycles after the accepting edge. For a hit on entry k that is k+1 cycles, for a miss it is 128 cycles, and each host write issued during the scan adds one more cycle. When the driver hands a word over, it computes the due cycle from the table contents it has written and from the writes it will issue during that scan, and pushes the expected fields together with that cycle. The monitor samples on the falling edge. It pops an item only when res_vld_o is seen, and compares both the fields and the cycle count, so an early, late, missing or extra result is reported.

// File: rtl/lm_pkg.sv
package lm_pkg;
  localparam int unsigned LM_LBL_W = 8;
  localparam int unsigned LM_SD_W  = 2;
  localparam int unsigned LM_RX_W  = LM_LBL_W + LM_SD_W;

  typedef struct packed {
    logic [1:0]          irq;
    logic [1:0]          chan;
    logic                fifo;
    logic                sd_any;
    logic [LM_SD_W-1:0]  sd;
    logic [LM_LBL_W-1:0] lbl;
  } lm_entry_t;

  typedef enum logic {LM_IDLE = 1'b0, LM_SCAN = 1'b1} lm_state_e;
endpackage

// File: rtl/lm_table.sv
module lm_table
  import lm_pkg::*;
#(
  parameter int unsigned N_ENT    = 128,
  parameter int unsigned HADDR_W  = 10,
  parameter int unsigned TBL_BASE = 32'h200
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [HADDR_W-1:0]         waddr_i,
  input  lm_entry_t                  wdata_i,
  input  logic [$clog2(N_ENT)-1:0]   rd_idx_i,
  output lm_entry_t                  rd_entry_o
);
  localparam int unsigned IDX_W = $clog2(N_ENT);

  logic [HADDR_W-1:0] off;
  logic               wr_hit;
  lm_entry_t          mem [N_ENT];

  // Below-base addresses wrap to a large offset and fail the range test.
  assign off    = waddr_i - HADDR_W'(TBL_BASE);
  assign wr_hit = we_i && (off < HADDR_W'(N_ENT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_ENT; i++) mem[i] <= '0;
    end else if (wr_hit) begin
      mem[off[IDX_W-1:0]] <= wdata_i;
    end
  end

  assign rd_entry_o = mem[rd_idx_i];
endmodule

// File: rtl/lm_compare.sv
module lm_compare
  import lm_pkg::*;
#(
  parameter int unsigned CH_W = 2
) (
  input  lm_entry_t             entry_i,
  input  logic [LM_LBL_W-1:0]   lbl_i,
  input  logic [LM_SD_W-1:0]    sd_i,
  input  logic [CH_W-1:0]       chan_i,
  input  logic                  all_call_i,
  output logic                  match_o
);
  logic lbl_ok, sd_ok, ch_ok;

  always_comb begin
    lbl_ok  = (entry_i.lbl == '0) || (entry_i.lbl == lbl_i);
    sd_ok   = entry_i.sd_any || (entry_i.sd == sd_i) || (all_call_i && (sd_i == '0));
    ch_ok   = (entry_i.chan == chan_i);
    match_o = lbl_ok && sd_ok && ch_ok;
  end
endmodule

// File: rtl/lm_scan_ctrl.sv
module lm_scan_ctrl
  import lm_pkg::*;
#(
  parameter int unsigned N_ENT = 128
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      start_i,
  input  logic                      stall_i,
  input  logic                      match_i,
  input  logic                      fifo_i,
  input  logic [1:0]                irq_i,
  output logic                      busy_o,
  output logic [$clog2(N_ENT)-1:0]  idx_o,
  output logic                      res_vld_o,
  output logic                      res_hit_o,
  output logic [$clog2(N_ENT)-1:0]  res_addr_o,
  output logic                      res_fifo_o,
  output logic [1:0]                res_irq_o
);
  localparam int unsigned IDX_W = $clog2(N_ENT);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_ENT - 1);

  lm_state_e st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= LM_IDLE;
      idx_o      <= '0;
      res_vld_o  <= 1'b0;
      res_hit_o  <= 1'b0;
      res_addr_o <= '0;
      res_fifo_o <= 1'b0;
      res_irq_o  <= '0;
    end else begin
      res_vld_o <= 1'b0;
      unique case (st_q)
        LM_IDLE: begin
          if (start_i) begin
            st_q  <= LM_SCAN;
            idx_o <= '0;
          end
        end
        LM_SCAN: begin
          if (!stall_i) begin
            if (match_i) begin
              st_q       <= LM_IDLE;
              res_vld_o  <= 1'b1;
              res_hit_o  <= 1'b1;
              res_addr_o <= idx_o;
              res_fifo_o <= fifo_i;
              res_irq_o  <= irq_i;
            end else if (idx_o == LAST) begin
              st_q       <= LM_IDLE;
              res_vld_o  <= 1'b1;
              res_hit_o  <= 1'b0;
              res_addr_o <= '0;
              res_fifo_o <= 1'b0;
              res_irq_o  <= '0;
            end else begin
              idx_o <= idx_o + 1'b1;
            end
          end
        end
        default: st_q <= LM_IDLE;
      endcase
    end
  end

  assign busy_o = (st_q == LM_SCAN);
endmodule

// File: rtl/lbl_match_engine.sv
module lbl_match_engine
  import lm_pkg::*;
#(
  parameter int unsigned N_ENT    = 128,
  parameter int unsigned N_CH     = 4,
  parameter int unsigned HADDR_W  = 10,
  parameter int unsigned TBL_BASE = 32'h200
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      word_vld_i,
  input  logic [LM_RX_W-1:0]        word_i,
  input  logic [$clog2(N_CH)-1:0]   word_ch_i,
  input  logic [N_CH-1:0]           all_call_i,
  input  logic                      tbl_we_i,
  input  logic [HADDR_W-1:0]        tbl_addr_i,
  input  logic [15:0]               tbl_wdata_i,
  output logic                      busy_o,
  output logic                      res_vld_o,
  output logic                      res_hit_o,
  output logic [$clog2(N_ENT)-1:0]  res_addr_o,
  output logic                      res_fifo_o,
  output logic [1:0]                res_irq_o
);
  localparam int unsigned IDX_W = $clog2(N_ENT);
  localparam int unsigned CH_W  = $clog2(N_CH);

  logic                  accept;
  logic [LM_LBL_W-1:0]   lbl_q;
  logic [LM_SD_W-1:0]    sd_q;
  logic [CH_W-1:0]       ch_q;
  logic                  ac_q;
  logic [IDX_W-1:0]      scan_idx;
  lm_entry_t             cur_entry;
  logic                  cur_match;

  assign accept = word_vld_i && !busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lbl_q <= '0;
      sd_q  <= '0;
      ch_q  <= '0;
      ac_q  <= 1'b0;
    end else if (accept) begin
      lbl_q <= word_i[LM_LBL_W-1:0];
      sd_q  <= word_i[LM_RX_W-1:LM_LBL_W];
      ch_q  <= word_ch_i;
      ac_q  <= all_call_i[word_ch_i];
    end
  end

  lm_table #(
    .N_ENT   (N_ENT),
    .HADDR_W (HADDR_W),
    .TBL_BASE(TBL_BASE)
  ) u_table (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (tbl_we_i),
    .waddr_i   (tbl_addr_i),
    .wdata_i   (lm_entry_t'(tbl_wdata_i)),
    .rd_idx_i  (scan_idx),
    .rd_entry_o(cur_entry)
  );

  lm_compare #(.CH_W(CH_W)) u_cmp (
    .entry_i   (cur_entry),
    .lbl_i     (lbl_q),
    .sd_i      (sd_q),
    .chan_i    (ch_q),
    .all_call_i(ac_q),
    .match_o   (cur_match)
  );

  lm_scan_ctrl #(.N_ENT(N_ENT)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (accept),
    .stall_i   (tbl_we_i),
    .match_i   (cur_match),
    .fifo_i    (cur_entry.fifo),
    .irq_i     (cur_entry.irq),
    .busy_o    (busy_o),
    .idx_o     (scan_idx),
    .res_vld_o (res_vld_o),
    .res_hit_o (res_hit_o),
    .res_addr_o(res_addr_o),
    .res_fifo_o(res_fifo_o),
    .res_irq_o (res_irq_o)
  );
endmodule

// File: rtl/lm_match_chk.sv
module lm_match_chk #(
  parameter int unsigned N_ENT = 128
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      word_vld_i,
  input logic                      tbl_we_i,
  input logic                      busy_o,
  input logic                      res_vld_o,
  input logic                      res_hit_o,
  input logic [$clog2(N_ENT)-1:0]  res_addr_o,
  input logic                      res_fifo_o,
  input logic [1:0]                res_irq_o,
  input logic [$clog2(N_ENT)-1:0]  scan_idx
);
  localparam int unsigned IDX_W = $clog2(N_ENT);

  // Entries evaluated so far in the current scan.
  logic [IDX_W:0] eval_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       eval_cnt <= '0;
    else if (!busy_o)  eval_cnt <= '0;
    else if (!tbl_we_i) eval_cnt <= eval_cnt + 1'b1;
  end

  p_scan_bound_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (eval_cnt < (IDX_W+1)'(N_ENT)));

  p_vld_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_vld_o |=> !res_vld_o);

  p_accept_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_vld_i && !busy_o) |=> busy_o);

  p_busy_fall_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> res_vld_o);

  p_idle_at_result_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_vld_o |-> !busy_o);

  p_stall_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && tbl_we_i) |=> (busy_o && scan_idx == $past(scan_idx)));

  p_hit_addr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_vld_o && res_hit_o) |-> (res_addr_o == $past(scan_idx)));

  p_miss_clean_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_vld_o && !res_hit_o) |-> (res_addr_o == '0 && !res_fifo_o && res_irq_o == '0));
endmodule

bind lbl_match_engine lm_match_chk #(.N_ENT(N_ENT)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .word_vld_i(word_vld_i),
  .tbl_we_i  (tbl_we_i),
  .busy_o    (busy_o),
  .res_vld_o (res_vld_o),
  .res_hit_o (res_hit_o),
  .res_addr_o(res_addr_o),
  .res_fifo_o(res_fifo_o),
  .res_irq_o (res_irq_o),
  .scan_idx  (scan_idx)
);

// File: tb/lbl_match_engine_tb_top.sv
module lbl_match_engine_tb_top;
  localparam int N_ENT = 128;
  localparam logic [15:0] FILL = 16'h33FF; // ch3, sd 11, label FF

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       word_vld = 1'b0;
  logic [9:0] word = '0;
  logic [1:0] word_ch = '0;
  logic [3:0] all_call = '0;
  logic       tbl_we = 1'b0;
  logic [9:0] tbl_addr = '0;
  logic [15:0] tbl_wdata = '0;
  logic       busy, res_vld, res_hit, res_fifo;
  logic [6:0] res_addr;
  logic [1:0] res_irq;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  logic [15:0] tb_tbl [N_ENT];

  typedef struct {
    bit    hit;
    int    addr;
    bit    fifo;
    int    irq;
    int    due;
    string tag;
  } exp_t;
  exp_t q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  lbl_match_engine dut_i (
    .clk_i(clk), .rst_ni(rst_n), .word_vld_i(word_vld), .word_i(word),
    .word_ch_i(word_ch), .all_call_i(all_call), .tbl_we_i(tbl_we),
    .tbl_addr_i(tbl_addr), .tbl_wdata_i(tbl_wdata), .busy_o(busy),
    .res_vld_o(res_vld), .res_hit_o(res_hit), .res_addr_o(res_addr),
    .res_fifo_o(res_fifo), .res_irq_o(res_irq)
  );

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic exp_t model(int ch, logic [9:0] w, bit ac);
    exp_t r;
    r.hit = 0; r.addr = 0; r.fifo = 0; r.irq = 0;
    for (int i = 0; i < N_ENT; i++) begin
      logic [15:0] e;
      bit lbl_ok, sd_ok, ch_ok;
      e = tb_tbl[i];
      lbl_ok = (e[7:0] == 8'h00) || (e[7:0] == w[7:0]);
      sd_ok  = e[10] || (e[9:8] == w[9:8]) || (ac && w[9:8] == 2'b00);
      ch_ok  = (int'(e[13:12]) == ch);
      if (lbl_ok && sd_ok && ch_ok) begin
        r.hit = 1; r.addr = i; r.fifo = e[11]; r.irq = int'(e[15:14]);
        return r;
      end
    end
    return r;
  endfunction

  // Starts and ends at a falling edge; we is high for one clock.
  task automatic tbl_wr(logic [9:0] a, logic [15:0] d);
    tbl_we = 1'b1; tbl_addr = a; tbl_wdata = d;
    if (a >= 10'h200 && a < 10'h280) tb_tbl[a - 10'h200] = d;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic issue_word(int ch, logic [9:0] w, logic [3:0] ac, int nstall, string tag);
    exp_t e;
    e = model(ch, w, ac[ch]);
    e.due = cyc + 1 + (e.hit ? e.addr + 1 : N_ENT) + nstall;
    e.tag = tag;
    q.push_back(e);
    word_vld = 1'b1; word = w; word_ch = 2'(ch); all_call = ac;
    @(negedge clk);
    word_vld = 1'b0;
    for (int i = 0; i < nstall; i++) tbl_wr(10'h27F, tb_tbl[127]);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
    all_call = '0;
  endtask

  task automatic send(int ch, logic [9:0] w, logic [3:0] ac, int nstall, string tag);
    issue_word(ch, w, ac, nstall, tag);
    wait_idle();
  endtask

  // Monitor: pop and compare when a result appears.
  always @(negedge clk) begin
    if (rst_n && res_vld) begin
      if (q.size() == 0) begin
        chk(0, "R10", "unexpected result", int'(res_addr), -1);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(res_hit == e.hit, e.tag, "hit", int'(res_hit), int'(e.hit));
        chk(int'(res_addr) == e.addr, e.tag, "addr", int'(res_addr), e.addr);
        chk(res_fifo == e.fifo, {e.tag, "/R7"}, "fifo", int'(res_fifo), int'(e.fifo));
        chk(int'(res_irq) == e.irq, {e.tag, "/R7"}, "irq", int'(res_irq), e.irq);
        chk(cyc == e.due, {e.tag, "/R9"}, "result cycle", cyc, e.due);
      end
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "R9", "watchdog expired", cyc, 0);
    finish_run();
  end

  initial begin
    for (int i = 0; i < N_ENT; i++) tb_tbl[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R12", "busy after reset", int'(busy), 0);
    chk(res_vld == 1'b0, "R12", "res_vld after reset", int'(res_vld), 0);

    // R12: cleared table, entry 0 accepts a channel-0 word with pair 00.
    send(0, {2'b00, 8'h55}, 4'b0000, 0, "R12");
    // R12: pair 01 fails every cleared entry.
    send(0, {2'b01, 8'h55}, 4'b0000, 0, "R12");

    for (int i = 0; i < N_ENT; i++) tbl_wr(10'(10'h200 + i), FILL);

    // R2: exact label and pair, ch1, fifo, irq2.
    tbl_wr(10'h20A, 16'h9942);
    send(1, {2'b01, 8'h42}, 4'b0000, 0, "R2");
    // R8: label differs.
    send(1, {2'b01, 8'h43}, 4'b0000, 0, "R8");

    // R3: pair don't-care with wildcard label, ch2, irq3.
    tbl_wr(10'h214, 16'hE400);
    send(2, {2'b11, 8'hA5}, 4'b0000, 0, "R3");

    // R6: entry 5 and entry 20 both accept; lower one wins.
    tbl_wr(10'h205, 16'h6277);
    send(2, {2'b10, 8'h77}, 4'b0000, 0, "R6");
    // R5: same word on channel 3 matches nothing.
    send(3, {2'b10, 8'h77}, 4'b0000, 0, "R5");

    // R4: all-call on the receiving channel only.
    tbl_wr(10'h21E, 16'h4211);
    send(0, {2'b00, 8'h11}, 4'b0000, 0, "R4");
    send(0, {2'b00, 8'h11}, 4'b0010, 0, "R4");
    send(0, {2'b00, 8'h11}, 4'b0001, 0, "R4");

    // R1: out-of-range writes must not clear entry 0 or entry 127.
    tbl_wr(10'h280, 16'h0000);
    tbl_wr(10'h1FF, 16'h0000);
    send(0, {2'b00, 8'h99}, 4'b0000, 0, "R1");

    // R11: three host writes during the scan.
    send(1, {2'b01, 8'h42}, 4'b0000, 3, "R11");

    // R10: a matching word offered mid-scan is dropped.
    issue_word(1, {2'b01, 8'h43}, 4'b0000, 0, "R10");
    repeat (5) @(negedge clk);
    word_vld = 1'b1; word = {2'b01, 8'h42}; word_ch = 2'd1;
    @(negedge clk);
    word_vld = 1'b0;
    wait_idle();
    repeat (3) @(negedge clk);
    chk(q.size() == 0, "R10", "pending results", q.size(), 0);

    // R9: last entry, full-length hit.
    tbl_wr(10'h27F, 16'hDB3C);
    send(1, {2'b11, 8'h3C}, 4'b0000, 0, "R9");

    repeat (3) @(negedge clk);
    chk(q.size() == 0, "R9", "results outstanding at end", q.size(), 0);
    finish_run();
  end
endmodule